// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns the address fields of a data-reference instruction into a 15-bit operand address. It handles three formats. The two-word format carries a 15-bit absolute address. The one-word direct format gives a 7-bit offset that is counted in three-word steps from a base register. The one-word indirect format uses a pointer that an earlier step has already fetched. The two-word and indirect formats can also be indexed. Eight index registers sit in ordinary memory, starting at the address held in the index pointer. A nonzero 3-bit index field selects one of them, and the block reads that word over a request/acknowledge memory port.

If a pre-increment is requested, the index word is raised by one and written back before it is used. The index value is treated as a signed 12-bit number. It is multiplied by the word length of the current data mode and added to the unindexed address. The sum is formed 24 bits wide and only its low 15 bits are kept. When the address is ready, a one-cycle valid pulse marks it, and the address is held until the next start.

A controller pulses `start` while the block is idle, with all instruction fields, the mode and both pointer registers steady on that cycle. It then waits for `ea_valid`.

Top module: `opaddr_gen`

## Requirements
- R1: During and after reset, `ea_valid`, `mem_req` and `busy` are low and `ea` is zero.
- R2: With format code 0 (two-word), `ea` equals the low 15 bits of the 24-bit sum of `far_addr` and the scaled index.
- R3: When the index field is 0, or the format is one-word direct, no memory request is made and `ea_valid` rises in the cycle after `start` is sampled.
- R4: A nonzero index field n causes a memory read at address `x0_reg + n`, wrapping modulo 2^15.
- R5: With `pre_inc` set, the word read is incremented modulo 2^12 and written back to the same address. The incremented value is the one used as the index, and the write follows the read's acknowledge.
- R6: The index word is sign-extended from 12 bits and multiplied by the mode's word count: mode 0 (fixed) gives 2, mode 1 (floating) gives 3, mode 2 (extended) gives 6, and mode 3 gives 3.
- R7: With format code 1 (one-word direct), `ea` equals `base_reg + 3*offset` modulo 2^15. The index field and `pre_inc` are ignored and no memory access is made.
- R8: With format code 2 (indirect), `ea` equals the low 15 bits of `far_addr` plus the scaled index, where `far_addr` carries the already-fetched pointer.
- R9: A pending memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`.
- R10: `ea_valid` is a single-cycle pulse and `ea` holds its value afterwards. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one address computation (sampled only when idle) |
| fmt | input | 2 | Format: 0 two-word, 1 one-word direct, 2 indirect |
| mode | input | 2 | Data mode: 0 fixed, 1 floating, 2 extended |
| idx_sel | input | 3 | Index register number, 0 = no indexing |
| pre_inc | input | 1 | Increment the index register and write it back before use |
| far_addr | input | 15 | Absolute address (two-word) or fetched pointer (indirect) |
| offset | input | 7 | One-word direct offset |
| base_reg | input | 15 | Base register |
| x0_reg | input | 15 | Address of index register 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge, completes the current request |
| busy | output | 1 | Computation in progress |
| ea | output | 15 | Effective operand address |
| ea_valid | output | 1 | One-cycle pulse when `ea` is ready |

## Verification
A vector table runs each format under every data mode. Positive, negative (all ones and the most negative 12-bit value) and wrapping index values separate correct sign extension and scaling from a zero-extended or wrongly scaled index. Near-top base and pointer values show that the 15-bit truncation wraps instead of saturating. Vectors with and without pre-increment, including an increment that wraps to zero, together with access counts and read and write addresses, tell a missed or extra memory cycle apart from a wrong sum. A directed run issues `start` while the block is busy, to show that the first request's fields are kept.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    localparam int ADDR_W  = 15;
    localparam int WORD_W  = 12;
    localparam int SUM_W   = 24;
    localparam int OFF_W   = 7;
    localparam int SEL_W   = 3;

    typedef enum logic [1:0] {
        FMT_LONG  = 2'd0,
        FMT_SHORT = 2'd1,
        FMT_INDIR = 2'd2,
        FMT_SPARE = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        DM_FIXED = 2'd0,
        DM_FLOAT = 2'd1,
        DM_EXT   = 2'd2,
        DM_SPARE = 2'd3
    } dmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             pinc;
        dmode_e           mode;
    } ctx_t;

    // words per operand for each data mode
    function automatic logic [2:0] word_count(dmode_e m);
        case (m)
            DM_FIXED: return 3'd2;
            DM_EXT:   return 3'd6;
            default:  return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/opaddr_base.sv
module opaddr_base
    import opaddr_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int OFFW = OFF_W
) (
    input  fmt_e            fmt,
    input  logic [AW-1:0]   far_addr,
    input  logic [AW-1:0]   base_reg,
    input  logic [OFFW-1:0] offset,
    output logic [AW-1:0]   unidx,
    output logic            idx_en
);
    logic [AW-1:0] off_ext;
    logic [AW-1:0] off_x3;

    assign off_ext = AW'(offset);
    assign off_x3  = off_ext + (off_ext << 1);

    always_comb begin
        if (fmt == FMT_SHORT) begin
            unidx  = base_reg + off_x3;
            idx_en = 1'b0;
        end else begin
            unidx  = far_addr;
            idx_en = 1'b1;
        end
    end
endmodule

// File: rtl/opaddr_scale.sv
module opaddr_scale
    import opaddr_pkg::*;
#(
    parameter int DW   = WORD_W,
    parameter int SUMW = SUM_W
) (
    input  logic [DW-1:0]   ival,
    input  dmode_e          mode,
    output logic [SUMW-1:0] scaled
);
    localparam int EXT_W = SUMW - DW;

    logic [SUMW-1:0] sext;
    logic [2:0]      wc;
    logic [SUMW-1:0] part [3];

    assign sext = {{EXT_W{ival[DW-1]}}, ival};
    assign wc   = word_count(mode);

    for (genvar b = 0; b < 3; b++) begin : g_part
        assign part[b] = wc[b] ? (sext << b) : '0;
    end

    assign scaled = part[0] + part[1] + part[2];
endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
    import opaddr_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = WORD_W,
    parameter int SW  = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          idx_en,
    input  logic [SW-1:0] idx_sel,
    input  logic          pre_inc,
    input  dmode_e        mode_in,
    input  logic [AW-1:0] unidx_in,
    input  logic [AW-1:0] x0_reg,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          ea_valid,
    output logic [AW-1:0] unidx_q,
    output logic [DW-1:0] ival_q,
    output dmode_e        mode_q
);
    step_e         st;
    ctx_t          ctx;
    logic [AW-1:0] x0_q;
    logic          need_idx;

    assign need_idx = idx_en && (idx_sel != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctx     <= '{sel: '0, pinc: 1'b0, mode: DM_FIXED};
            x0_q    <= '0;
            unidx_q <= '0;
            ival_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    ctx     <= '{sel: idx_sel, pinc: pre_inc, mode: mode_in};
                    x0_q    <= x0_reg;
                    unidx_q <= unidx_in;
                    ival_q  <= '0;
                    st      <= need_idx ? ST_READ : ST_DONE;
                end
                ST_READ: if (mem_ack) begin
                    ival_q <= ctx.pinc ? mem_rdata + DW'(1) : mem_rdata;
                    st     <= ctx.pinc ? ST_WRITE : ST_DONE;
                end
                ST_WRITE: if (mem_ack) st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
    assign mem_we    = (st == ST_WRITE);
    assign mem_addr  = x0_q + AW'(ctx.sel);
    assign mem_wdata = ival_q;
    assign busy      = (st != ST_IDLE);
    assign ea_valid  = (st == ST_DONE);
    assign mode_q    = ctx.mode;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        ea_valid |=> !ea_valid);

    a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !$past(mem_req && mem_we))
            |-> $past(mem_req && !mem_we && mem_ack));

    a_r3_direct_valid: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !need_idx) |=> (ea_valid && !mem_req));
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = WORD_W,
    parameter int SUMW = SUM_W,
    parameter int OFFW = OFF_W,
    parameter int SW   = SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      fmt,
    input  logic [1:0]      mode,
    input  logic [SW-1:0]   idx_sel,
    input  logic            pre_inc,
    input  logic [AW-1:0]   far_addr,
    input  logic [OFFW-1:0] offset,
    input  logic [AW-1:0]   base_reg,
    input  logic [AW-1:0]   x0_reg,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            busy,
    output logic [AW-1:0]   ea,
    output logic            ea_valid
);
    logic [AW-1:0]   unidx;
    logic            idx_en;
    logic [AW-1:0]   unidx_q;
    logic [DW-1:0]   ival_q;
    dmode_e          mode_q;
    logic [SUMW-1:0] scaled;
    logic [SUMW-1:0] sum;

    opaddr_base #(.AW(AW), .OFFW(OFFW)) u_base (
        .fmt      (fmt_e'(fmt)),
        .far_addr (far_addr),
        .base_reg (base_reg),
        .offset   (offset),
        .unidx    (unidx),
        .idx_en   (idx_en)
    );

    opaddr_ctrl #(.AW(AW), .DW(DW), .SW(SW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .idx_en    (idx_en),
        .idx_sel   (idx_sel),
        .pre_inc   (pre_inc),
        .mode_in   (dmode_e'(mode)),
        .unidx_in  (unidx),
        .x0_reg    (x0_reg),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .busy      (busy),
        .ea_valid  (ea_valid),
        .unidx_q   (unidx_q),
        .ival_q    (ival_q),
        .mode_q    (mode_q)
    );

    opaddr_scale #(.DW(DW), .SUMW(SUMW)) u_scale (
        .ival   (ival_q),
        .mode   (mode_q),
        .scaled (scaled)
    );

    // wide sum, then keep the address bits only
    assign sum = SUMW'(unidx_q) + scaled;
    assign ea  = sum[AW-1:0];

    a_r7_short_no_mem: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && fmt == 2'd1) |=> (ea_valid && !mem_req));

    a_r10_ea_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && $past(ea_valid)) |-> $stable(ea));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !ea_valid));
endmodule

// File: tb/test_opaddr_gen.sv
module test_opaddr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  fmt, mode;
    logic [2:0]  idx_sel;
    logic        pre_inc;
    logic [14:0] far_addr, base_reg, x0_reg;
    logic [6:0]  offset;
    logic        mem_req, mem_we, mem_ack, busy, ea_valid;
    logic [14:0] mem_addr, ea;
    logic [11:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int cyc    = 0;
    logic [14:0] rd_addr, wr_addr, hold_addr;
    logic [11:0] mem [256];

    always #2 clk = ~clk;

    opaddr_gen i_opaddr_gen (
        .clk(clk), .rst(rst), .start(start), .fmt(fmt), .mode(mode),
        .idx_sel(idx_sel), .pre_inc(pre_inc), .far_addr(far_addr),
        .offset(offset), .base_reg(base_reg), .x0_reg(x0_reg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .ea(ea), .ea_valid(ea_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: acknowledge one cycle after a request appears
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    wr_addr <= mem_addr;
                end else begin
                    rd_cnt  <= rd_cnt + 1;
                    rd_addr <= mem_addr;
                end
            end
        end
    end

    // R9: address must not move between request and acknowledge
    always @(negedge clk) begin
        if (!rst && mem_req && !mem_ack) hold_addr <= mem_addr;
        if (!rst && mem_req && mem_ack) chk("R9 address held", 32'(mem_addr), 32'(hold_addr));
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0]  fmt;
        logic [1:0]  mode;
        logic [2:0]  idx;
        logic        pinc;
        logic [14:0] far;
        logic [6:0]  off;
        logic [14:0] base;
        logic [14:0] x0;
        logic [11:0] mval;
        logic [14:0] exp_ea;
        logic [11:0] exp_wb;
        logic [1:0]  exp_acc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 3'd0, 1'b0, 15'h1234, 7'h00, 15'h0000, 15'h0000, 12'h000, 15'h1234, 12'h000, 2'd0},
        '{2'd0, 2'd1, 3'd2, 1'b0, 15'h1000, 7'h00, 15'h0000, 15'h0010, 12'h005, 15'h100F, 12'h000, 2'd1},
        '{2'd0, 2'd2, 3'd1, 1'b1, 15'h0200, 7'h00, 15'h0000, 15'h0020, 12'h004, 15'h021E, 12'h005, 2'd2},
        '{2'd0, 2'd0, 3'd3, 1'b0, 15'h0100, 7'h00, 15'h0000, 15'h0030, 12'hFFF, 15'h00FE, 12'h000, 2'd1},
        '{2'd0, 2'd1, 3'd7, 1'b1, 15'h0050, 7'h00, 15'h0000, 15'h0040, 12'hFFF, 15'h0050, 12'h000, 2'd2},
        '{2'd1, 2'd1, 3'd4, 1'b1, 15'h0000, 7'h7F, 15'h0100, 15'h0080, 12'h001, 15'h027D, 12'h000, 2'd0},
        '{2'd1, 2'd0, 3'd0, 1'b0, 15'h0000, 7'h01, 15'h7FFF, 15'h0000, 12'h000, 15'h0002, 12'h000, 2'd0},
        '{2'd2, 2'd0, 3'd1, 1'b0, 15'h7FFE, 7'h00, 15'h0000, 15'h0050, 12'h002, 15'h0002, 12'h000, 2'd1},
        '{2'd0, 2'd2, 3'd5, 1'b0, 15'h7000, 7'h00, 15'h0000, 15'h0060, 12'h800, 15'h4000, 12'h000, 2'd1},
        '{2'd0, 2'd3, 3'd6, 1'b0, 15'h0000, 7'h00, 15'h0000, 15'h0070, 12'h001, 15'h0003, 12'h000, 2'd1}
    };

    task automatic drive(input vec_t v);
        fmt = v.fmt; mode = v.mode; idx_sel = v.idx; pre_inc = v.pinc;
        far_addr = v.far; offset = v.off; base_reg = v.base; x0_reg = v.x0;
    endtask

    // waits for ea_valid; returns cycles waited after start is dropped
    task automatic wait_valid(output int waited);
        waited = 0;
        while (!ea_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int n);
        int    waited;
        string tag;
        logic [7:0] slot;
        tag  = (v.fmt == 2'd1) ? "R7" : (v.fmt == 2'd2) ? "R8" : "R2";
        slot = 8'(v.x0 + 15'(v.idx));
        mem[slot] = v.mval;
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid(waited);
        chk($sformatf("%s vector %0d ea_valid", tag, n), 32'(ea_valid), 32'd1);
        chk($sformatf("%s/R6 vector %0d ea", tag, n), 32'(ea), 32'(v.exp_ea));
        chk($sformatf("R3/R7 vector %0d access count", n), 32'(rd_cnt + wr_cnt), 32'(v.exp_acc));
        if (v.exp_acc == 2'd0)
            chk($sformatf("R3 vector %0d latency", n), 32'(waited), 32'd0);
        else
            chk($sformatf("R4 vector %0d read address", n), 32'(rd_addr), 32'(v.x0 + 15'(v.idx)));
        if (v.exp_acc == 2'd2) begin
            chk($sformatf("R5 vector %0d write address", n), 32'(wr_addr), 32'(rd_addr));
            chk($sformatf("R5 vector %0d written value", n), 32'(mem[slot]), 32'(v.exp_wb));
        end
        @(negedge clk);
        chk($sformatf("R10 vector %0d pulse ends", n), 32'(ea_valid), 32'd0);
        chk($sformatf("R10 vector %0d ea holds", n), 32'(ea), 32'(v.exp_ea));
    endtask

    initial begin
        int waited;
        rst = 1'b1; start = 1'b0;
        drive('0);
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset ea_valid", 32'(ea_valid), 32'd0);
        chk("R1 reset mem_req", 32'(mem_req), 32'd0);
        chk("R1 reset busy", 32'(busy), 32'd0);
        chk("R1 reset ea", 32'(ea), 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // R10: start while busy is ignored
        mem[8'h12] = 12'h005;
        @(negedge clk);
        drive(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        chk("R10 busy after start", 32'(busy), 32'd1);
        far_addr = 15'h0777; idx_sel = 3'd0;
        @(negedge clk);
        start = 1'b0;
        wait_valid(waited);
        chk("R10 first request kept", 32'(ea), 32'h100F);
        repeat (4) begin
            @(negedge clk);
            chk("R10 no second result", 32'(ea_valid), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule